// File: doc/BRIEF.md
# Transmit Scavenger with Per-Source Packet Binning

This block sits on the transmit side of a shared-buffer switch. Every receiver that can send to this transmitter owns one swap ring, and each ring shows this block one slot at a time. A slot holds a descriptor for a fixed-size 256-byte buffer: a buffer pointer, start and end flags, and an importance code. The scavenger visits the rings in turn. Whenever it takes a buffer out of a slot, it writes a replacement pointer back into that same slot in the same cycle.

A long packet arrives as several buffers. Each ring has its own bin that gathers a packet's pointers until the last fragment is seen. Only then is the complete pointer list sent to the transmit queue, one pointer per cycle. A stalled or half-sent packet therefore stays inside its own bin and never holds up the other rings. When the local free list runs low, buffers of low importance are thrown away. A thrown-away buffer is handed straight back to its own slot, so no free buffer is spent on it.

The controller has three states: SCAN, EMIT and PURGE.
- In SCAN it judges the slot of the current ring as IDLE (empty slot, go to the next ring), WAIT (no free buffer, stay on the same ring), KEEP or DROP.
- Transitions out of SCAN: a KEEP of an end fragment moves to EMIT. A KEEP of a start fragment while the bin is open moves to PURGE, holding the new fragment aside. A DROP while the bin is open moves to PURGE. Every other KEEP or DROP advances to the next ring.
- EMIT returns to SCAN after the last pointer and advances the ring.
- PURGE returns the binned pointers to the free list. It then either restores the held fragment (and moves to EMIT if that fragment also ends its packet) or returns to SCAN on the next ring.

Top module: `tx_scavenger`

## Requirements
- R1: When every ring keeps supplying one-buffer packets, successive packets on the transmit queue come from ring indices that each increase by one, wrapping modulo NRING.
- R2: A kept buffer is taken from the current ring. In the same cycle `ring_fill_ptr` carries the free-list head `fl_ptr` and `fl_pop` is high. At most one ring is taken per cycle, and only a ring whose `ring_valid` is high.
- R3: A packet is queued only after its end fragment arrives. Its pointers come out on consecutive cycles in arrival order, with `tq_src` naming the ring and `tq_last` high only on the final pointer. `ring_sop`=1 marks a start fragment and `ring_eop`=1 marks an end fragment; a fragment with both flags set is a one-buffer packet.
- R4: A ring with an open, incomplete packet does not delay complete packets from other rings.
- R5: A start fragment arriving while that ring's bin is open discards the old bin. Its pointers go out on `fl_push`, in arrival order. The new fragment then opens a fresh bin.
- R6: A fragment with `ring_sop`=0 that arrives at an empty bin is dropped. Its slot is refilled with its own pointer, `fl_pop` stays low, and nothing is queued.
- R7: A fragment with `ring_sop`=0 that arrives at a bin already holding MAX_FRAGS pointers is dropped. The bin's pointers are pushed back to the free list.
- R8: When `fl_level` < LOW_MARK, a buffer with `ring_kind` < KEEP_MIN is dropped: its own pointer refills the slot, and any open bin on that ring is pushed back. Kinds of KEEP_MIN or more are kept under pressure, and every kind is kept when `fl_level` >= LOW_MARK.
- R9: When `fl_level` is 0 and the current slot would be kept, no ring is taken until a free buffer appears. The scan stays on that ring during the wait.
- R10: After reset no ring is taken, and `fl_pop`, `fl_push` and `tq_valid` are low.
- R11: In any one cycle at most one of these happens: a ring take, a queue beat, or a free-list push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_valid | input | NRING | Slot of each ring holds a newly owned buffer |
| ring_ptr | input | NRING*PTR_W | Buffer pointer per ring slot |
| ring_sop | input | NRING | Start-of-packet flag per slot |
| ring_eop | input | NRING | End-of-packet flag per slot |
| ring_kind | input | NRING*KIND_W | Importance code per slot |
| ring_take | output | NRING | One-hot take strobe for a ring slot |
| ring_fill_ptr | output | PTR_W | Pointer written back into the taken slot |
| fl_level | input | LVL_W | Free buffers available (saturating) |
| fl_ptr | input | PTR_W | Head of the local free list |
| fl_pop | output | 1 | Consume the free-list head |
| fl_push | output | 1 | Return a pointer to the free list |
| fl_push_ptr | output | PTR_W | Pointer being returned |
| tq_valid | output | 1 | Transmit-queue beat valid |
| tq_ptr | output | PTR_W | Buffer pointer of the beat |
| tq_src | output | RW | Source ring of the packet |
| tq_last | output | 1 | Final pointer of the packet |

## Verification
The assertions check the per-cycle rules on every cycle:
- a take is one-hot and only hits a valid slot;
- a pop comes with a take and never with an empty free list;
- a dropped slot gets its own pointer back;
- a low-importance buffer under pressure never consumes a free buffer;
- takes, beats and pushes are mutually exclusive;
- a packet burst keeps one source.

Only the bench scenarios can show the behaviours that depend on history:
- the round-robin order;
- that a packet is held back until it is complete;
- that an incomplete packet on one ring does not delay the others;
- the order of the purged pointers;
- the dropping of stray and overflowing fragments;
- the stall on an empty free list, which lasts many cycles.

// File: rtl/txscv_pkg.sv
`timescale 1ns/1ps
package txscv_pkg;
    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_PURGE = 2'd2
    } scv_state_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_WAIT = 2'd1,
        ACT_KEEP = 2'd2,
        ACT_DROP = 2'd3
    } slot_act_e;
endpackage

// File: rtl/txscv_judge.sv
`timescale 1ns/1ps
module txscv_judge
    import txscv_pkg::*;
#(
    parameter int KIND_W    = 2,
    parameter int LVL_W     = 4,
    parameter int CW        = 3,
    parameter int MAX_FRAGS = 4,
    parameter int LOW_MARK  = 2,
    parameter int KEEP_MIN  = 2
) (
    input  logic              slot_vld,
    input  logic              slot_sop,
    input  logic [KIND_W-1:0] slot_kind,
    input  logic [CW-1:0]     bin_cnt,
    input  logic [LVL_W-1:0]  free_lvl,
    output slot_act_e         act
);
    logic pressured;
    logic minor;
    logic stray;
    logic overfull;

    always_comb begin
        pressured = free_lvl < LVL_W'(LOW_MARK);
        minor     = slot_kind < KIND_W'(KEEP_MIN);
        stray     = !slot_sop && (bin_cnt == '0);
        overfull  = !slot_sop && (bin_cnt == CW'(MAX_FRAGS));
        if (!slot_vld)
            act = ACT_IDLE;
        else if ((pressured && minor) || stray || overfull)
            act = ACT_DROP;
        else if (free_lvl == '0)
            act = ACT_WAIT;
        else
            act = ACT_KEEP;
    end
endmodule

// File: rtl/txscv_bins.sv
`timescale 1ns/1ps
module txscv_bins #(
    parameter int NRING     = 4,
    parameter int PTR_W     = 8,
    parameter int MAX_FRAGS = 4,
    localparam int RW = (NRING > 1) ? $clog2(NRING) : 1,
    localparam int IW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_ring,
    input  logic [IW-1:0]    wr_idx,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [RW-1:0]    rd_ring,
    input  logic [IW-1:0]    rd_idx,
    output logic [PTR_W-1:0] rd_ptr
);
    logic [PTR_W-1:0] rd_each [NRING];

    for (genvar g = 0; g < NRING; g++) begin : g_bin
        logic [PTR_W-1:0] slots [MAX_FRAGS];
        always_ff @(posedge clk) begin
            if (wr_en && wr_ring == RW'(g))
                slots[wr_idx] <= wr_ptr;
        end
        assign rd_each[g] = slots[rd_idx];
    end

    assign rd_ptr = rd_each[rd_ring];
endmodule

// File: rtl/tx_scavenger.sv
`timescale 1ns/1ps
module tx_scavenger
    import txscv_pkg::*;
#(
    parameter int NRING     = 4,
    parameter int PTR_W     = 8,
    parameter int KIND_W    = 2,
    parameter int LVL_W     = 4,
    parameter int MAX_FRAGS = 4,
    parameter int LOW_MARK  = 2,
    parameter int KEEP_MIN  = 2,
    localparam int RW = (NRING > 1) ? $clog2(NRING) : 1,
    localparam int IW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1,
    localparam int CW = $clog2(MAX_FRAGS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRING-1:0]        ring_valid,
    input  logic [NRING*PTR_W-1:0]  ring_ptr,
    input  logic [NRING-1:0]        ring_sop,
    input  logic [NRING-1:0]        ring_eop,
    input  logic [NRING*KIND_W-1:0] ring_kind,
    output logic [NRING-1:0]        ring_take,
    output logic [PTR_W-1:0]        ring_fill_ptr,
    input  logic [LVL_W-1:0]        fl_level,
    input  logic [PTR_W-1:0]        fl_ptr,
    output logic                    fl_pop,
    output logic                    fl_push,
    output logic [PTR_W-1:0]        fl_push_ptr,
    output logic                    tq_valid,
    output logic [PTR_W-1:0]        tq_ptr,
    output logic [RW-1:0]           tq_src,
    output logic                    tq_last
);
    scv_state_e        state;
    slot_act_e         act;
    logic [RW-1:0]     cur;
    logic [RW-1:0]     cur_n;
    logic [CW-1:0]     cnt [NRING];
    logic [CW-1:0]     cur_cnt;
    logic [IW-1:0]     idx;
    logic              idx_last;
    logic              pend_vld;
    logic              pend_eop;
    logic [PTR_W-1:0]  pend_ptr;

    logic [PTR_W-1:0]  sel_ptr;
    logic [KIND_W-1:0] sel_kind;
    logic              sel_sop;
    logic              sel_eop;

    logic              bin_wr;
    logic [IW-1:0]     bin_wr_idx;
    logic [PTR_W-1:0]  bin_wr_ptr;
    logic [PTR_W-1:0]  bin_rd_ptr;

    assign sel_ptr  = ring_ptr[cur*PTR_W +: PTR_W];
    assign sel_kind = ring_kind[cur*KIND_W +: KIND_W];
    assign sel_sop  = ring_sop[cur];
    assign sel_eop  = ring_eop[cur];
    assign cur_cnt  = cnt[cur];
    assign cur_n    = (cur == RW'(NRING - 1)) ? '0 : cur + 1'b1;
    assign idx_last = (CW'(idx) + CW'(1)) == cur_cnt;

    txscv_judge #(
        .KIND_W(KIND_W), .LVL_W(LVL_W), .CW(CW),
        .MAX_FRAGS(MAX_FRAGS), .LOW_MARK(LOW_MARK), .KEEP_MIN(KEEP_MIN)
    ) u_judge (
        .slot_vld (ring_valid[cur]),
        .slot_sop (sel_sop),
        .slot_kind(sel_kind),
        .bin_cnt  (cur_cnt),
        .free_lvl (fl_level),
        .act      (act)
    );

    txscv_bins #(
        .NRING(NRING), .PTR_W(PTR_W), .MAX_FRAGS(MAX_FRAGS)
    ) u_bins (
        .clk    (clk),
        .wr_en  (bin_wr),
        .wr_ring(cur),
        .wr_idx (bin_wr_idx),
        .wr_ptr (bin_wr_ptr),
        .rd_ring(cur),
        .rd_idx (idx),
        .rd_ptr (bin_rd_ptr)
    );

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SCAN;
            cur      <= '0;
            idx      <= '0;
            pend_vld <= 1'b0;
            pend_eop <= 1'b0;
            pend_ptr <= '0;
            for (int r = 0; r < NRING; r++) cnt[r] <= '0;
        end else begin
            unique case (state)
                ST_SCAN: begin
                    unique case (act)
                        ACT_IDLE: cur <= cur_n;
                        ACT_WAIT: ;
                        ACT_DROP: begin
                            if (cur_cnt != '0) begin
                                state    <= ST_PURGE;
                                idx      <= '0;
                                pend_vld <= 1'b0;
                            end else begin
                                cur <= cur_n;
                            end
                        end
                        ACT_KEEP: begin
                            if (sel_sop && cur_cnt != '0) begin
                                state    <= ST_PURGE;
                                idx      <= '0;
                                pend_vld <= 1'b1;
                                pend_eop <= sel_eop;
                                pend_ptr <= sel_ptr;
                            end else begin
                                cnt[cur] <= sel_sop ? CW'(1) : cur_cnt + CW'(1);
                                if (sel_eop) begin
                                    state <= ST_EMIT;
                                    idx   <= '0;
                                end else begin
                                    cur <= cur_n;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                ST_EMIT: begin
                    if (idx_last) begin
                        cnt[cur] <= '0;
                        state    <= ST_SCAN;
                        cur      <= cur_n;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_PURGE: begin
                    if (idx_last) begin
                        if (pend_vld) begin
                            cnt[cur] <= CW'(1);
                            pend_vld <= 1'b0;
                            if (pend_eop) begin
                                state <= ST_EMIT;
                                idx   <= '0;
                            end else begin
                                state <= ST_SCAN;
                                cur   <= cur_n;
                            end
                        end else begin
                            cnt[cur] <= '0;
                            state    <= ST_SCAN;
                            cur      <= cur_n;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_SCAN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ring_take     = '0;
        ring_fill_ptr = '0;
        fl_pop        = 1'b0;
        fl_push       = 1'b0;
        fl_push_ptr   = '0;
        tq_valid      = 1'b0;
        tq_ptr        = '0;
        tq_src        = cur;
        tq_last       = 1'b0;
        bin_wr        = 1'b0;
        bin_wr_idx    = '0;
        bin_wr_ptr    = sel_ptr;
        unique case (state)
            ST_SCAN: begin
                if (act == ACT_KEEP) begin
                    ring_take[cur] = 1'b1;
                    ring_fill_ptr  = fl_ptr;
                    fl_pop         = 1'b1;
                    bin_wr         = !(sel_sop && cur_cnt != '0);
                    bin_wr_idx     = sel_sop ? '0 : cur_cnt[IW-1:0];
                end else if (act == ACT_DROP) begin
                    ring_take[cur] = 1'b1;
                    ring_fill_ptr  = sel_ptr;
                end
            end
            ST_EMIT: begin
                tq_valid = 1'b1;
                tq_ptr   = bin_rd_ptr;
                tq_last  = idx_last;
            end
            ST_PURGE: begin
                fl_push     = 1'b1;
                fl_push_ptr = bin_rd_ptr;
                if (idx_last && pend_vld) begin
                    bin_wr     = 1'b1;
                    bin_wr_idx = '0;
                    bin_wr_ptr = pend_ptr;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tx_scavenger_chk.sv
`timescale 1ns/1ps
module tx_scavenger_chk #(
    parameter int NRING     = 4,
    parameter int PTR_W     = 8,
    parameter int KIND_W    = 2,
    parameter int LVL_W     = 4,
    parameter int LOW_MARK  = 2,
    parameter int KEEP_MIN  = 2,
    localparam int RW = (NRING > 1) ? $clog2(NRING) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NRING-1:0]        ring_valid,
    input logic [NRING*PTR_W-1:0]  ring_ptr,
    input logic [NRING*KIND_W-1:0] ring_kind,
    input logic [NRING-1:0]        ring_take,
    input logic [PTR_W-1:0]        ring_fill_ptr,
    input logic [LVL_W-1:0]        fl_level,
    input logic                    fl_pop,
    input logic                    fl_push,
    input logic                    tq_valid,
    input logic [RW-1:0]           tq_src,
    input logic                    tq_last
);
    logic [PTR_W-1:0]  taken_ptr;
    logic [KIND_W-1:0] taken_kind;
    logic              any_take;

    always_comb begin
        taken_ptr  = '0;
        taken_kind = '0;
        for (int r = 0; r < NRING; r++) begin
            if (ring_take[r]) begin
                taken_ptr  = ring_ptr[r*PTR_W +: PTR_W];
                taken_kind = ring_kind[r*KIND_W +: KIND_W];
            end
        end
    end
    assign any_take = |ring_take;

    a_r2_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring_take));
    a_r2_take_valid_slot: assert property (@(posedge clk) disable iff (!rst_n)
        any_take |-> ((ring_take & ~ring_valid) == '0));
    a_r2_pop_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop |-> any_take);
    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop |-> (fl_level != '0));
    a_r6_drop_own_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (any_take && !fl_pop) |-> (ring_fill_ptr == taken_ptr));
    a_r8_minor_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (any_take && fl_level < LVL_W'(LOW_MARK) && taken_kind < KIND_W'(KEEP_MIN)) |-> !fl_pop);
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tq_valid, fl_push, any_take}) <= 1);
    a_r3_burst_one_src: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_valid && !tq_last) |=> (tq_valid && $stable(tq_src)));
endmodule

bind tx_scavenger tx_scavenger_chk #(
    .NRING(NRING), .PTR_W(PTR_W), .KIND_W(KIND_W), .LVL_W(LVL_W),
    .LOW_MARK(LOW_MARK), .KEEP_MIN(KEEP_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_valid(ring_valid), .ring_ptr(ring_ptr),
    .ring_kind(ring_kind), .ring_take(ring_take), .ring_fill_ptr(ring_fill_ptr),
    .fl_level(fl_level), .fl_pop(fl_pop), .fl_push(fl_push),
    .tq_valid(tq_valid), .tq_src(tq_src), .tq_last(tq_last)
);

// File: tb/tx_scavenger_bench.sv
`timescale 1ns/1ps
module tx_scavenger_bench;
    localparam int N  = 4;
    localparam int PW = 8;
    localparam int KW = 2;
    localparam int LW = 4;
    localparam int RW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    ring_valid = '0;
    logic [N*PW-1:0] ring_ptr = '0;
    logic [N-1:0]    ring_sop = '0;
    logic [N-1:0]    ring_eop = '0;
    logic [N*KW-1:0] ring_kind = '0;
    logic [N-1:0]    ring_take;
    logic [PW-1:0]   ring_fill_ptr;
    logic [LW-1:0]   fl_level = '0;
    logic [PW-1:0]   fl_ptr = '0;
    logic            fl_pop, fl_push, tq_valid, tq_last;
    logic [PW-1:0]   fl_push_ptr, tq_ptr;
    logic [RW-1:0]   tq_src;

    tx_scavenger u_tx_scavenger (
        .clk(clk), .rst_n(rst_n), .ring_valid(ring_valid), .ring_ptr(ring_ptr),
        .ring_sop(ring_sop), .ring_eop(ring_eop), .ring_kind(ring_kind),
        .ring_take(ring_take), .ring_fill_ptr(ring_fill_ptr),
        .fl_level(fl_level), .fl_ptr(fl_ptr), .fl_pop(fl_pop),
        .fl_push(fl_push), .fl_push_ptr(fl_push_ptr),
        .tq_valid(tq_valid), .tq_ptr(tq_ptr), .tq_src(tq_src), .tq_last(tq_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit live = 0;

    // Ring models
    logic [PW-1:0] rq_ptr  [N][64];
    logic          rq_sop  [N][64];
    logic          rq_eop  [N][64];
    logic [KW-1:0] rq_kind [N][64];
    logic          rq_drop [N][64];
    string         rq_tag  [N][64];
    int            rq_hd [N];
    int            rq_tl [N];
    // Expected transmit beats per source
    logic [PW:0]   eq_beat [N][64];
    int            eq_hd [N];
    int            eq_tl [N];
    // Expected pushes and free list model
    logic [PW-1:0] ep_ptr [64];
    int            ep_hd = 0;
    int            ep_tl = 0;
    logic [PW-1:0] fq [1024];
    int            fhd = 0;
    int            ftl = 0;
    // Round-robin tracking
    bit            rr_on = 0;
    int            rr_prev = -1;
    bit            rr_new = 1;
    int            nxt = 8'h80;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int r, input logic [PW-1:0] p, input bit s, input bit e,
                       input int k, input bit d, input string tag);
        rq_ptr[r][rq_tl[r]]  = p;
        rq_sop[r][rq_tl[r]]  = s;
        rq_eop[r][rq_tl[r]]  = e;
        rq_kind[r][rq_tl[r]] = KW'(k);
        rq_drop[r][rq_tl[r]] = d;
        rq_tag[r][rq_tl[r]]  = tag;
        rq_tl[r]++;
    endtask

    task automatic want_out(input int r, input logic [PW-1:0] p, input bit last);
        eq_beat[r][eq_tl[r]] = {last, p};
        eq_tl[r]++;
    endtask

    task automatic want_push(input logic [PW-1:0] p);
        ep_ptr[ep_tl] = p;
        ep_tl++;
    endtask

    function automatic logic [PW-1:0] np();
        nxt++;
        return PW'(nxt);
    endfunction

    function automatic bit quiet();
        bit q = (ep_hd == ep_tl);
        for (int r = 0; r < N; r++)
            if (rq_hd[r] != rq_tl[r] || eq_hd[r] != eq_tl[r]) q = 0;
        return q;
    endfunction

    task automatic drain(input string tag);
        int w = 0;
        while (!quiet() && w < 400) begin
            @(posedge clk); #1;
            w++;
        end
        chk(quiet(), tag, w, 0);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic observe();
        int nev;
        int s;
        nev = int'(tq_valid) + int'(fl_push) + $countones(ring_take);
        if (nev > 1) chk(0, "R11 overlapping actions", nev, 1);
        if (tq_valid) begin
            s = int'(tq_src);
            if (eq_hd[s] == eq_tl[s]) begin
                chk(0, "R3 unexpected queue beat", {tq_last, tq_ptr}, 0);
            end else begin
                chk({tq_last, tq_ptr} == eq_beat[s][eq_hd[s]], "R3 queue beat",
                    {tq_last, tq_ptr}, eq_beat[s][eq_hd[s]]);
                eq_hd[s]++;
            end
            if (rr_on && rr_new) begin
                if (rr_prev >= 0)
                    chk(s == (rr_prev + 1) % N, "R1 round-robin order", s, (rr_prev + 1) % N);
                rr_prev = s;
            end
            rr_new = tq_last;
        end
        if (fl_push) begin
            if (ep_hd == ep_tl) begin
                chk(0, "R5 unexpected push", fl_push_ptr, 0);
            end else begin
                chk(fl_push_ptr == ep_ptr[ep_hd], "R5 push order", fl_push_ptr, ep_ptr[ep_hd]);
                ep_hd++;
            end
            fq[ftl] = fl_push_ptr;
            ftl++;
        end
        for (int r = 0; r < N; r++) begin
            if (ring_take[r]) begin
                if (rq_hd[r] == rq_tl[r]) begin
                    chk(0, "R2 take of empty ring", r, -1);
                end else if (rq_drop[r][rq_hd[r]]) begin
                    chk(ring_fill_ptr == rq_ptr[r][rq_hd[r]] && !fl_pop,
                        {rq_tag[r][rq_hd[r]], " drop refill"}, ring_fill_ptr, rq_ptr[r][rq_hd[r]]);
                    rq_hd[r]++;
                end else begin
                    chk(fl_pop && ftl > fhd && ring_fill_ptr == fq[fhd],
                        {rq_tag[r][rq_hd[r]], " keep refill"}, ring_fill_ptr, fq[fhd]);
                    rq_hd[r]++;
                end
            end
        end
        if (fl_pop && ftl > fhd) fhd++;
    endtask

    task automatic drive();
        int c;
        for (int r = 0; r < N; r++) begin
            ring_valid[r] = rq_hd[r] != rq_tl[r];
            ring_ptr[r*PW +: PW]  = ring_valid[r] ? rq_ptr[r][rq_hd[r]] : '0;
            ring_sop[r]           = ring_valid[r] ? rq_sop[r][rq_hd[r]] : 1'b0;
            ring_eop[r]           = ring_valid[r] ? rq_eop[r][rq_hd[r]] : 1'b0;
            ring_kind[r*KW +: KW] = ring_valid[r] ? rq_kind[r][rq_hd[r]] : '0;
        end
        c = ftl - fhd;
        fl_level = LW'((c > 15) ? 15 : c);
        fl_ptr   = (c > 0) ? fq[fhd] : '0;
    endtask

    initial begin
        for (int r = 0; r < N; r++) begin
            rq_hd[r] = 0; rq_tl[r] = 0; eq_hd[r] = 0; eq_tl[r] = 0;
        end
        for (int i = 0; i < 64; i++) fq[i] = PW'(i);
        ftl = 64;
        forever begin
            @(negedge clk);
            cycles++;
            drive();
            #1;
            if (live) observe();
            if (cycles > 150000) begin
                chk(0, "watchdog", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [PW-1:0] a, b, c, d, e;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1.5;
        // R10: idle after reset
        chk(ring_take == '0 && !fl_pop && !fl_push && !tq_valid, "R10 reset idle",
            {ring_take, fl_pop, fl_push, tq_valid}, 0);
        live = 1;
        @(posedge clk); #1;

        // R2, R3, R8: one-buffer packets on every ring, low kind with ample free list
        for (int r = 0; r < N; r++) begin
            a = np();
            put(r, a, 1, 1, 0, 0, "R8 minor kept when plenty");
            want_out(r, a, 1);
        end
        drain("R2 singles drained");

        // R1: two packets per ring, round-robin service
        rr_on = 1; rr_prev = -1; rr_new = 1;
        for (int k = 0; k < 2; k++)
            for (int r = 0; r < N; r++) begin
                a = np();
                put(r, a, 1, 1, 3, 0, "R2");
                want_out(r, a, 1);
            end
        drain("R1 round-robin drained");
        rr_on = 0;

        // R3: multi-fragment packets on two rings
        a = np(); b = np(); c = np();
        put(0, a, 1, 0, 3, 0, "R3"); put(0, b, 0, 0, 3, 0, "R3"); put(0, c, 0, 1, 3, 0, "R3");
        want_out(0, a, 0); want_out(0, b, 0); want_out(0, c, 1);
        d = np(); e = np();
        put(2, d, 1, 0, 2, 0, "R3"); put(2, e, 0, 1, 2, 0, "R3");
        want_out(2, d, 0); want_out(2, e, 1);
        drain("R3 fragments drained");

        // R4: incomplete packet on ring 1, complete ones on ring 3
        a = np(); b = np();
        put(1, a, 1, 0, 3, 0, "R4"); put(1, b, 0, 0, 3, 0, "R4");
        c = np(); d = np();
        put(3, c, 1, 1, 3, 0, "R4"); put(3, d, 1, 1, 3, 0, "R4");
        want_out(3, c, 1); want_out(3, d, 1);
        repeat (40) @(posedge clk);
        #1;
        chk(eq_hd[3] == eq_tl[3], "R4 other ring served", eq_tl[3] - eq_hd[3], 0);
        chk(rq_hd[1] == rq_tl[1], "R4 partial taken", rq_tl[1] - rq_hd[1], 0);
        e = np();
        put(1, e, 0, 1, 3, 0, "R4");
        want_out(1, a, 0); want_out(1, b, 0); want_out(1, e, 1);
        drain("R4 completion drained");

        // R5: restart while bin open
        a = np(); b = np(); c = np();
        put(0, a, 1, 0, 3, 0, "R5"); put(0, b, 0, 0, 3, 0, "R5");
        put(0, c, 1, 1, 3, 0, "R5");
        want_push(a); want_push(b); want_out(0, c, 1);
        drain("R5 restart drained");

        // R6: stray fragments with no open bin
        a = np(); b = np();
        put(2, a, 0, 0, 3, 1, "R6"); put(2, b, 0, 1, 3, 1, "R6");
        drain("R6 strays drained");

        // R7: overflow of a bin
        a = np(); b = np(); c = np(); d = np();
        put(1, a, 1, 0, 3, 0, "R7"); put(1, b, 0, 0, 3, 0, "R7");
        put(1, c, 0, 0, 3, 0, "R7"); put(1, d, 0, 0, 3, 0, "R7");
        e = np();
        put(1, e, 0, 0, 3, 1, "R7");
        put(1, np(), 0, 1, 3, 1, "R7");
        want_push(a); want_push(b); want_push(c); want_push(d);
        drain("R7 overflow drained");

        // R8: pressure, one free buffer left
        fhd = ftl - 1;
        a = np(); b = np();
        put(0, a, 1, 0, 3, 0, "R8"); put(0, b, 0, 0, 0, 1, "R8");
        want_push(a);
        drain("R8 pressure purge drained");
        a = np(); b = np();
        put(0, a, 1, 1, 0, 1, "R8"); put(0, b, 1, 1, 2, 0, "R8");
        want_out(0, b, 1);
        drain("R8 pressure singles drained");
        chk(ftl == fhd, "R8 free list now empty", ftl - fhd, 0);

        // R9: stall with empty free list
        a = np();
        put(0, a, 1, 1, 3, 0, "R9");
        want_out(0, a, 1);
        repeat (12) @(posedge clk);
        #1;
        b = np();
        put(1, b, 1, 1, 0, 1, "R9");
        repeat (20) @(posedge clk);
        #1;
        chk(rq_hd[0] != rq_tl[0], "R9 keep buffer waits", rq_tl[0] - rq_hd[0], 1);
        chk(rq_hd[1] != rq_tl[1], "R9 scan held on ring", rq_tl[1] - rq_hd[1], 1);
        chk(eq_hd[0] != eq_tl[0], "R9 nothing queued", eq_tl[0] - eq_hd[0], 1);
        fq[ftl] = 8'h70;
        ftl++;
        drain("R9 resumed drained");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule